// File: doc/BRIEF.md
# Four-Lane SD Data Block Receiver

This block sits on the host side of an SD card link and takes in one data block over the four-bit DAT bus. It samples the four lines on each rising edge of the card clock. It waits for a start marker, then rebuilds payload bytes from pairs of nibbles and hands each byte out with a single-cycle strobe and its position in the block. After the payload, it checks the trailer that each line sends on its own: a 16-bit CRC followed by an end bit. It then reports completion together with an error flag.

The receiver is armed by its own pulse and does not depend on the command path. Block data can begin while the response to the read command is still arriving, so the controller should arm the receiver at the moment it issues the read command. If no start marker arrives within a programmable number of clocks, the receiver gives up, reports a timeout and goes back to idle.

Top module: `sd4_block_rx`

## Requirements
- R1: After reset, `byte_valid`, `block_done`, `crc_error`, `timeout` and `busy` are all low.
- R2: An `arm` pulse in idle makes the receiver look for a start marker, which is a sample with all four lines low. The first sample after the arm edge already counts.
- R3: Each payload byte is formed from two consecutive samples. The first sample gives bits 7:4 and the second gives bits 3:0, and within each nibble `dat[3]` is the most significant bit. The bytes come out with indices 0, 1, 2, … in the order they arrive.
- R4: A block gives exactly BLOCK_BYTES (default 512) `byte_valid` pulses, one clock each, and two pulses are never on adjacent cycles. The payload phase lasts 2×BLOCK_BYTES clocks.
- R5: Each line has its own CRC over its payload bits, with polynomial 0x1021 (x^16+x^12+x^5+1) and a start value of 0. It is received MSB first over the 16 clocks after the payload. When all four CRCs match and the end-bit sample is 4'hF, `block_done` pulses for one cycle with `crc_error` low.
- R6: If the CRC on any single line differs, `crc_error` pulses high in the same cycle as `block_done`. `crc_error` is never high without `block_done`.
- R7: If any line is low in the end-bit sample, `crc_error` is reported with `block_done`, even when every CRC matches.
- R8: If none of the first `tmo_limit` samples after arming is a start marker, `timeout` pulses for one cycle directly after the `tmo_limit`-th sample and the receiver returns to idle (`busy` low). A marker on the `tmo_limit`-th sample is still accepted.
- R9: An `arm` pulse while a block is in progress has no effect. The block finishes with all its bytes and a single `block_done`.
- R10: When the receiver is not armed, including after a timeout, activity on the DAT lines produces no bytes, no `block_done` and no `crc_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Single-cycle request to receive one block |
| tmo_limit | input | TMO_W | Number of samples allowed before a start marker |
| dat | input | 4 | The four DAT lines |
| byte_valid | output | 1 | One-cycle strobe for a payload byte |
| byte_data | output | 8 | Payload byte |
| byte_index | output | IDX_W | Position of the byte within the block |
| block_done | output | 1 | One-cycle pulse once the end bit has been sampled |
| crc_error | output | 1 | CRC or end-bit fault, valid with block_done |
| timeout | output | 1 | One-cycle pulse when no start marker arrived in time |
| busy | output | 1 | Receiver armed or receiving |

## Verification
On every cycle, the assertions check the pulse discipline: strobes are never adjacent, `block_done` and `timeout` last one cycle each, `crc_error` only appears together with `block_done`, a timeout always leaves the receiver idle, and a line's CRC fault is only latched during its trailer window. Byte values and their ordering, the trailer CRC arithmetic, the exact clock on which a timeout fires, and the fact that stray arms and unarmed traffic are ignored can only be shown by the bench's scenarios. In those scenarios, bytes and CRCs are computed from the bit order the requirements give. The blocks cover the 0xF0 pattern, a pattern that contains all 256 byte values, a corrupted CRC on each line in turn, and a bad end bit.

// File: rtl/sd4_rx_pkg.sv
package sd4_rx_pkg;
  localparam int LANES = 4;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_CRC,
    ST_END
  } rx_state_t;
endpackage

// File: rtl/sd4_crc_lane.sv
module sd4_crc_lane
  import sd4_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic calc_en,
  input  logic chk_en,
  input  logic bit_in,
  output logic mismatch
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             err_q, err_d;
  logic             fb;

  always_comb begin
    crc_d = crc_q;
    err_d = err_q;
    fb    = bit_in ^ crc_q[CRC_W-1];
    if (clr) begin
      crc_d = '0;
      err_d = 1'b0;
    end else if (calc_en) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end else if (chk_en) begin
      // trailer arrives MSB first: compare then shift the running value out
      if (bit_in != crc_q[CRC_W-1]) err_d = 1'b1;
      crc_d = {crc_q[CRC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
      err_q <= 1'b0;
    end else begin
      crc_q <= crc_d;
      err_q <= err_d;
    end
  end

  assign mismatch = err_q;

  assert_err_only_in_check_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(chk_en));
endmodule

// File: rtl/sd4_byte_pack.sv
module sd4_byte_pack #(
  parameter int BLOCK_BYTES = 512,
  localparam int IDX_W = $clog2(BLOCK_BYTES),
  localparam int NIB_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NIB_W-1:0] nib_idx,
  input  logic [3:0]       dat,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [IDX_W-1:0] byte_index
);
  logic [3:0]       hi_q, hi_d;
  logic             vld_q, vld_d;
  logic [7:0]       data_q, data_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    hi_d   = hi_q;
    vld_d  = 1'b0;
    data_d = data_q;
    idx_d  = idx_q;
    if (en && !nib_idx[0]) hi_d = dat;
    if (en && nib_idx[0]) begin
      vld_d  = 1'b1;
      data_d = {hi_q, dat};
      idx_d  = nib_idx[NIB_W-1:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
      idx_q  <= '0;
    end else begin
      hi_q   <= hi_d;
      vld_q  <= vld_d;
      data_q <= data_d;
      idx_q  <= idx_d;
    end
  end

  assign byte_valid = vld_q;
  assign byte_data  = data_q;
  assign byte_index = idx_q;

  assert_strobe_spaced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/sd4_rx_ctrl.sv
module sd4_rx_ctrl
  import sd4_rx_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int TMO_W = 16,
  localparam int NIB_W = $clog2(BLOCK_BYTES) + 1,
  localparam int CNT_W = (NIB_W > TMO_W) ? NIB_W : TMO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [3:0]       dat,
  input  logic             lane_err,
  output logic             calc_en,
  output logic             chk_en,
  output logic             clr,
  output logic [NIB_W-1:0] nib_idx,
  output logic             block_done,
  output logic             crc_error,
  output logic             timeout,
  output logic             busy
);
  localparam logic [NIB_W-1:0] NIB_LAST = NIB_W'(BLOCK_BYTES * 2 - 1);
  localparam logic [3:0]       CRC_LAST = 4'(CRC_W - 1);

  rx_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             tmo_q, tmo_d;
  logic [TMO_W-1:0] wait_last;

  assign wait_last = tmo_limit - {{(TMO_W-1){1'b0}}, 1'b1};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    tmo_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (arm) begin
        state_d = ST_WAIT;
        cnt_d   = '0;
      end
      ST_WAIT: begin
        if (dat == 4'h0) begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end else if (cnt_q[TMO_W-1:0] == wait_last) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_DATA: begin
        if (cnt_q[NIB_W-1:0] == NIB_LAST) begin
          state_d = ST_CRC;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_CRC: begin
        if (cnt_q[3:0] == CRC_LAST) begin
          state_d = ST_END;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_END: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        err_d   = lane_err | (dat != 4'hF);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
      tmo_q   <= tmo_d;
    end
  end

  assign calc_en    = (state_q == ST_DATA);
  assign chk_en     = (state_q == ST_CRC);
  assign clr        = (state_q == ST_WAIT);
  assign nib_idx    = cnt_q[NIB_W-1:0];
  assign block_done = done_q;
  assign crc_error  = err_q;
  assign timeout    = tmo_q;
  assign busy       = (state_q != ST_IDLE);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_error_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q);
  assert_timeout_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (!busy && !done_q));
  assert_timeout_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |=> !tmo_q);
endmodule

// File: rtl/sd4_block_rx.sv
module sd4_block_rx
  import sd4_rx_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int TMO_W = 16,
  localparam int IDX_W = $clog2(BLOCK_BYTES),
  localparam int NIB_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [3:0]       dat,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [IDX_W-1:0] byte_index,
  output logic             block_done,
  output logic             crc_error,
  output logic             timeout,
  output logic             busy
);
  logic             calc_en, chk_en, clr;
  logic [NIB_W-1:0] nib_idx;
  logic [LANES-1:0] lane_bad;

  sd4_rx_ctrl #(.BLOCK_BYTES(BLOCK_BYTES), .TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .tmo_limit(tmo_limit), .dat(dat),
    .lane_err(|lane_bad), .calc_en(calc_en), .chk_en(chk_en), .clr(clr),
    .nib_idx(nib_idx), .block_done(block_done), .crc_error(crc_error),
    .timeout(timeout), .busy(busy)
  );

  sd4_byte_pack #(.BLOCK_BYTES(BLOCK_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .en(calc_en), .nib_idx(nib_idx), .dat(dat),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_index(byte_index)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sd4_crc_lane u_crc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .calc_en(calc_en),
      .chk_en(chk_en), .bit_in(dat[g]), .mismatch(lane_bad[g])
    );
  end
endmodule

// File: tb/sd4_block_rx_bench.sv
`timescale 1ns/1ps
module sd4_block_rx_bench;
  localparam int BB = 512;
  localparam int TW = 16;
  localparam int LIMIT = 40;

  logic          clk = 1'b0;
  logic          rst_n, arm;
  logic [TW-1:0] tmo_limit;
  logic [3:0]    dat;
  logic          byte_valid, block_done, crc_error, timeout, busy;
  logic [7:0]    byte_data;
  logic [8:0]    byte_index;

  always #2 clk = ~clk;

  sd4_block_rx #(.BLOCK_BYTES(BB), .TMO_W(TW)) u_sd4_block_rx (
    .clk(clk), .rst_n(rst_n), .arm(arm), .tmo_limit(tmo_limit), .dat(dat),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_index(byte_index),
    .block_done(block_done), .crc_error(crc_error), .timeout(timeout), .busy(busy)
  );

  int n_chk = 0, n_bad = 0;
  int n_bytes, n_done, n_crc, n_tmo, exp_idx;
  logic [7:0] blk [BB];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3: bytes compared against the block, index must follow arrival order
  always @(negedge clk) if (rst_n) begin
    if (byte_valid) begin
      check(byte_index == exp_idx[8:0], "R3 index", int'(byte_index), exp_idx);
      check(byte_data == blk[byte_index], "R3 data", int'(byte_data), int'(blk[byte_index]));
      exp_idx++;
      n_bytes++;
    end
    if (block_done) n_done++;
    if (crc_error) n_crc++;
    if (timeout) n_tmo++;
  end

  function automatic logic [15:0] lane_crc(input int lane);
    logic [15:0] c = '0;
    logic [3:0]  nib;
    logic        fb;
    for (int i = 0; i < BB; i++)
      for (int h = 0; h < 2; h++) begin
        nib = (h == 0) ? blk[i][7:4] : blk[i][3:0];
        fb  = nib[lane] ^ c[15];
        c   = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    return c;
  endfunction

  task automatic clear_counts();
    n_bytes = 0; n_done = 0; n_crc = 0; n_tmo = 0; exp_idx = 0;
  endtask

  task automatic send(input int d, input bit do_arm, input int bad_crc, input int bad_end,
                      input bit mid_arm);
    logic [15:0] cr [4];
    for (int l = 0; l < 4; l++) cr[l] = lane_crc(l);
    if (bad_crc >= 0) cr[bad_crc][5] = ~cr[bad_crc][5];
    @(negedge clk);
    clear_counts();
    arm = do_arm; dat = 4'hF;
    @(negedge clk);
    arm = 1'b0;
    for (int k = 0; k < d; k++) begin dat = 4'hF; @(negedge clk); end
    dat = 4'h0; @(negedge clk);
    for (int i = 0; i < BB; i++)
      for (int h = 0; h < 2; h++) begin
        dat = (h == 0) ? blk[i][7:4] : blk[i][3:0];
        arm = (mid_arm && i == 100 && h == 0);
        @(negedge clk);
      end
    arm = 1'b0;
    for (int k = 0; k < 16; k++) begin
      for (int l = 0; l < 4; l++) dat[l] = cr[l][15-k];
      @(negedge clk);
    end
    dat = 4'hF;
    if (bad_end >= 0) dat[bad_end] = 1'b0;
    @(negedge clk);
    dat = 4'hF;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_block(input string req, input int nb, input int nd, input int nc);
    check(n_bytes == nb, {req, " byte count"}, n_bytes, nb);
    check(n_done == nd, {req, " done count"}, n_done, nd);
    check(n_crc == nc, {req, " crc_error count"}, n_crc, nc);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; arm = 1'b0; dat = 4'hF; tmo_limit = TW'(LIMIT);
    clear_counts();
    for (int i = 0; i < BB; i++) blk[i] = 8'hF0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({byte_valid, block_done, crc_error, timeout, busy} == 5'b0, "R1 reset outputs",
          int'({byte_valid, block_done, crc_error, timeout, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R5: 0xF0 block, start a few clocks after arming
    send(3, 1'b1, -1, -1, 1'b0);
    expect_block("R5 pattern F0", BB, 1, 0);
    check(busy == 1'b0, "R5 idle after block", int'(busy), 0);

    // R2/R4: every byte value, start on the first sample after arm
    for (int i = 0; i < BB; i++) blk[i] = 8'((i * 37 + 11) & 255);
    send(0, 1'b1, -1, -1, 1'b0);
    expect_block("R2 R4 full sweep", BB, 1, 0);

    // R6: corrupt each lane's CRC in turn
    for (int i = 0; i < BB; i++) blk[i] = 8'(i ^ 8'h5A);
    for (int l = 0; l < 4; l++) begin
      send(2, 1'b1, l, -1, 1'b0);
      expect_block($sformatf("R6 bad crc lane %0d", l), BB, 1, 1);
    end

    // R7: one line low during the end bit
    send(1, 1'b1, -1, 2, 1'b0);
    expect_block("R7 bad end bit", BB, 1, 1);

    // R9: arm during payload ignored
    send(1, 1'b1, -1, -1, 1'b1);
    expect_block("R9 arm while busy", BB, 1, 0);

    // R10: block on the lines with no arm
    send(1, 1'b0, -1, -1, 1'b0);
    expect_block("R10 unarmed traffic", 0, 0, 0);

    // R8: timeout timing
    @(negedge clk);
    clear_counts();
    arm = 1'b1; dat = 4'hF;
    @(negedge clk);
    arm = 1'b0;
    repeat (LIMIT - 1) @(negedge clk);
    check(timeout == 1'b0, "R8 no early timeout", int'(timeout), 0);
    check(busy == 1'b1, "R8 still waiting", int'(busy), 1);
    @(negedge clk);
    check(timeout == 1'b1, "R8 timeout pulse", int'(timeout), 1);
    check(busy == 1'b0, "R8 idle after timeout", int'(busy), 0);
    @(negedge clk);
    check(timeout == 1'b0, "R8 timeout one cycle", int'(timeout), 0);

    // R8: start on the last allowed sample is accepted
    send(LIMIT - 1, 1'b1, -1, -1, 1'b0);
    expect_block("R8 late start accepted", BB, 1, 0);
    check(n_tmo == 0, "R8 no timeout on late start", n_tmo, 0);

    // R8/R10: start one sample too late -> timeout, block ignored
    send(LIMIT, 1'b1, -1, -1, 1'b0);
    expect_block("R10 after timeout", 0, 0, 0);
    check(n_tmo == 1, "R8 timeout counted", n_tmo, 1);

    finish_run();
  end
endmodule